// File: doc/BRIEF.md
# I2C Master SCL Baud Generator

This block sets the SCL timing for an I2C master. It uses a down-counting timer that reloads itself. The reload value is the low seven bits of an eight-bit baud configuration register.

The counter is armed when software writes the transmit data buffer. From then on it decrements once for every phase tick it receives. A tick arrives on either of two phases, so the counter decrements twice per instruction cycle.

- **Rollover.** A tick that finds the counter at zero is a rollover. The generator toggles SCL, raises a one-cycle rollover strobe and reloads the counter. One SCL half-period therefore lasts reload+1 ticks, and a full period lasts two rollovers. This gives f_SCL = f_instruction / (reload + 1).
- **Clock stretching.** A reload happens only when the sampled bus level equals the driven level. While a slave holds the line low after a release, the counter parks at zero.
- **End of transfer.** When the transfer-done input reports that the final acknowledge has been clocked, counting halts, the counter parks at zero and SCL keeps its last level.

Top module: `sclgen_top`

## Requirements
- R1: A synchronous active-low reset drives `scl_o` high, `roll_o` low and `brg_count` to 0, and leaves the block idle. Afterwards, phase ticks change nothing until a buffer write occurs.
- R2: The reload value is `baud_cfg[6:0]`. Bit 7 of `baud_cfg` has no effect on the count or on the SCL period.
- R3: A `buf_wr` pulse loads `brg_count` with the reload value in that same clock edge and starts counting.
- R4: While running, `brg_count` decrements by one in each cycle where `phase_tick[0]` or `phase_tick[1]` is high. It holds in cycles without a tick.
- R5: Each SCL half-period lasts exactly reload+1 ticks, from the buffer write or from the previous toggle. A full SCL period is therefore 2*(reload+1) ticks. With reload 0, every tick toggles SCL.
- R6: On a rollover (a tick while the count is 0 and the bus level matches), `scl_o` toggles and `brg_count` reloads with the current reload value.
- R7: On a tick at count 0 where `scl_in` differs from `scl_o`, `scl_o` does not toggle and `brg_count` stays 0. The first tick after the levels match again performs the rollover.
- R8: An `xfer_done` pulse halts counting. `brg_count` goes to 0, `scl_o` keeps its level, and later ticks change nothing until the next `buf_wr`.
- R9: When `buf_wr` and `xfer_done` are high in the same cycle, the buffer write wins: the counter loads and counting continues.
- R10: `roll_o` is high for exactly the one cycle in which `scl_o` shows a new level, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_tick | input | 2 | Per-phase count enables, at most one high per cycle |
| baud_cfg | input | 8 | Baud configuration register; bits 6:0 give the reload value |
| buf_wr | input | 1 | Transmit-buffer write strobe; arms the generator |
| xfer_done | input | 1 | Final acknowledge has been clocked; halts counting |
| scl_in | input | 1 | Sampled SCL bus level |
| scl_o | output | 1 | Driven SCL level (1 = released high) |
| roll_o | output | 1 | One-cycle strobe on each SCL toggle |
| brg_count | output | 7 | Current counter value |

## Verification
The half-period is measured in ticks for six configuration/spacing pairs:
- The three 400/312.5/100 kHz reloads from a 10 MHz instruction rate (0x18, 0x1F, 0x63) set the normal timing.
- A reload of 0 shows that every tick toggles SCL.
- A mid-range reload with wide gaps between ticks shows that idle cycles are not counted.
- A value with bit 7 set shows that the top bit plays no part.

Directed cases then separate the other behaviours:
- a stretched high phase, where the counter must park and not reload;
- a halt in the middle of a half-period, where SCL must hold;
- a simultaneous write and halt;
- tick-free cycles after an arm;
- ticks sent before any arm.

// File: rtl/sclgen_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the SCL baud generator.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package sclgen_pkg;

    // Run state of the generator.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sclgen_state_e;

    // Counter commands issued by the controller.
    // At most one field is set in any cycle.
    typedef struct packed {
        logic clear;
        logic load;
        logic dec;
    } sclgen_cmd_t;

endpackage

// File: rtl/sclgen_tick_merge.sv
`timescale 1ns/1ps
// Module: sclgen_tick_merge
// Merges the per-phase tick enables into one count enable per cycle.
// Assumes: the phase ticks are mutually exclusive, so the OR of them
// never loses a tick.
module sclgen_tick_merge #(
    parameter int NUM_PHASES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] phase_tick,
    output logic                  tick
);

    logic [NUM_PHASES:0] chain;

    assign chain[0] = 1'b0;

    // OR each phase into the running chain.
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        assign chain[g+1] = chain[g] | phase_tick[g];
    end

    assign tick = chain[NUM_PHASES];

    // R4: the phases never overlap, so one merged tick stands for exactly one phase.
    a_r4_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_tick));

endmodule

// File: rtl/sclgen_downcnt.sv
`timescale 1ns/1ps
// Module: sclgen_downcnt
// Down counter with a reload value.
// Command priority: clear, then load, then decrement.
// The counter never wraps below zero.
// Assumes: the controller issues no decrement while the count is zero.
module sclgen_downcnt #(
    parameter int WIDTH = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  sclgen_pkg::sclgen_cmd_t    cmd,
    input  logic [WIDTH-1:0]           load_val,
    output logic [WIDTH-1:0]           count,
    output logic                       is_zero
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] count_q;

    // Update the count from the highest-priority command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cmd.clear) begin
            count_q <= '0;
        end else if (cmd.load) begin
            count_q <= load_val;
        end else if (cmd.dec) begin
            count_q <= count_q - ONE;
        end
    end

    assign count   = count_q;
    assign is_zero = (count_q == '0);

    // R6: a load places the reload value in the counter.
    a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.load && !cmd.clear) |=> (count_q == $past(load_val)));

    // R4: with no command, the count holds.
    a_r4_hold_without_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd.clear && !cmd.load && !cmd.dec) |=> $stable(count_q));

    // R4: a decrement lowers the count by exactly one.
    a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.dec && !cmd.load && !cmd.clear) |=> (count_q == $past(count_q) - ONE));

    // R7: the counter is never asked to go below zero.
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.dec |-> (count_q != '0));

endmodule

// File: rtl/sclgen_ctrl.sv
`timescale 1ns/1ps
// Module: sclgen_ctrl
// Run/idle control and the SCL level register.
// - Arms on a buffer write.
// - Decrements on each tick while running.
// - Toggles SCL and reloads at a rollover, but only when the bus level
//   matches the driven level.
// - Halts on transfer done.
// Assumes: scl_in is already synchronous to clk.
module sclgen_ctrl (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        buf_wr,
    input  logic                        xfer_done,
    input  logic                        scl_in,
    input  logic                        cnt_zero,
    output sclgen_pkg::sclgen_cmd_t     cmd,
    output logic                        scl_o,
    output logic                        roll_o
);

    import sclgen_pkg::*;

    sclgen_state_e state_q, state_d;
    logic          scl_q;
    logic          roll_q;
    logic          toggle;
    logic          bus_match;

    assign bus_match = (scl_in == scl_q);

    // Decide the next state, the counter command and whether SCL toggles.
    always_comb begin
        state_d   = state_q;
        cmd.clear = 1'b0;
        cmd.load  = 1'b0;
        cmd.dec   = 1'b0;
        toggle    = 1'b0;
        if (buf_wr) begin
            cmd.load = 1'b1;
            state_d  = ST_RUN;
        end else if (xfer_done) begin
            cmd.clear = 1'b1;
            state_d   = ST_IDLE;
        end else if (state_q == ST_RUN && tick) begin
            if (!cnt_zero) begin
                cmd.dec = 1'b1;
            end else if (bus_match) begin
                cmd.load = 1'b1;
                toggle   = 1'b1;
            end
        end
    end

    // Register the run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Register the SCL level and the rollover strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            roll_q <= 1'b0;
        end else begin
            roll_q <= toggle;
            if (toggle) begin
                scl_q <= ~scl_q;
            end
        end
    end

    assign scl_o  = scl_q;
    assign roll_o = roll_q;

    // R8: while idle and not re-armed, SCL keeps its level.
    a_r8_idle_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !buf_wr) |=> $stable(scl_q));

    // R7: a tick at zero against a mismatched bus level leaves SCL unchanged.
    a_r7_stretch_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && cnt_zero && !bus_match && !buf_wr && !xfer_done)
        |=> $stable(scl_q));

    // R10: the strobe coincides with a change of SCL level.
    a_r10_roll_marks_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(roll_q) |-> (scl_q != $past(scl_q)));

    // R9: a buffer write always leaves the block running.
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> (state_q == ST_RUN));

endmodule

// File: rtl/sclgen_top.sv
`timescale 1ns/1ps
// Module: sclgen_top
// SCL baud generator for an I2C master.
// The reload value is the low bits of the baud register. Each rollover
// of the down counter toggles SCL.
// Assumes: the phase ticks are mutually exclusive. Start/stop sequencing
// and data shifting are handled by a neighbouring block.
module sclgen_top #(
    parameter int NUM_PHASES = 2,
    parameter int CFG_W      = 8,
    parameter int RELOAD_W   = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] phase_tick,
    input  logic [CFG_W-1:0]      baud_cfg,
    input  logic                  buf_wr,
    input  logic                  xfer_done,
    input  logic                  scl_in,
    output logic                  scl_o,
    output logic                  roll_o,
    output logic [RELOAD_W-1:0]   brg_count
);

    localparam int SPARE_W = CFG_W - RELOAD_W;

    logic                    tick;
    logic                    cnt_zero;
    logic [RELOAD_W-1:0]     reload_val;
    sclgen_pkg::sclgen_cmd_t cmd;

    // The spare configuration bits are deliberately ignored.
    logic [SPARE_W-1:0]      cfg_unused;

    assign reload_val = baud_cfg[RELOAD_W-1:0];
    assign cfg_unused = baud_cfg[CFG_W-1:RELOAD_W];

    sclgen_tick_merge #(
        .NUM_PHASES (NUM_PHASES)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_tick (phase_tick),
        .tick       (tick)
    );

    sclgen_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .buf_wr    (buf_wr),
        .xfer_done (xfer_done),
        .scl_in    (scl_in),
        .cnt_zero  (cnt_zero),
        .cmd       (cmd),
        .scl_o     (scl_o),
        .roll_o    (roll_o)
    );

    sclgen_downcnt #(
        .WIDTH (RELOAD_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .load_val (reload_val),
        .count    (brg_count),
        .is_zero  (cnt_zero)
    );

    // R3: the cycle after a write shows the reload value in the counter.
    a_r3_arm_loads: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> (brg_count == $past(reload_val)));

    // R8: after a halt the counter is parked at zero.
    a_r8_halt_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !buf_wr) |=> (brg_count == '0));

endmodule

// File: tb/sclgen_top_test.sv
`timescale 1ns/1ps
// Bench for sclgen_top.
// A vector table of (config, tick gap, expected half-period) is walked by
// one loop. Directed tests follow for reset, stretching, halting and
// priority.
module sclgen_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase_tick = 2'b00;
    logic [7:0] baud_cfg = 8'h00;
    logic       buf_wr = 1'b0;
    logic       xfer_done = 1'b0;
    logic       hold_low = 1'b0;
    logic       scl_in;
    logic       scl_o;
    logic       roll_o;
    logic [6:0] brg_count;

    int  checks = 0;
    int  errors = 0;
    bit  phase_sel = 1'b0;
    bit  finished = 1'b0;

    // Bus model: open drain, with an optional slave holding the line low.
    assign scl_in = scl_o & ~hold_low;

    always #2.5 clk = ~clk;

    sclgen_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_tick (phase_tick),
        .baud_cfg   (baud_cfg),
        .buf_wr     (buf_wr),
        .xfer_done  (xfer_done),
        .scl_in     (scl_in),
        .scl_o      (scl_o),
        .roll_o     (roll_o),
        .brg_count  (brg_count)
    );

    localparam int NVEC = 6;
    localparam logic [7:0] VEC_CFG  [NVEC] = '{8'h18, 8'h1F, 8'h63, 8'h00, 8'h09, 8'h85};
    localparam int         VEC_GAP  [NVEC] = '{0, 1, 0, 2, 3, 0};
    localparam int         VEC_HALF [NVEC] = '{25, 32, 100, 1, 10, 6};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait gap idle cycles, then send one tick on alternating phases.
    // Returns at a negedge, after the design has seen the tick.
    task automatic tick_once(input int gap);
        repeat (gap) @(negedge clk);
        phase_tick = phase_sel ? 2'b10 : 2'b01;
        phase_sel  = ~phase_sel;
        @(negedge clk);
        phase_tick = 2'b00;
    endtask

    task automatic pulse_write(input logic [7:0] cfg);
        baud_cfg = cfg;
        buf_wr   = 1'b1;
        @(negedge clk);
        buf_wr   = 1'b0;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    // Count ticks until SCL changes level. Also checks the strobe.
    task automatic measure_half(input int gap, output int n);
        logic prev = scl_o;
        n = 0;
        for (int k = 0; k < 400; k++) begin
            tick_once(gap);
            n++;
            if (scl_o != prev) break;
        end
        check("R10 roll strobe at toggle", int'(roll_o), 1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R5: watchdog expired, actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values, and ticks have no effect before an arm.
        check("R1 scl after reset", int'(scl_o), 1);
        check("R1 roll after reset", int'(roll_o), 0);
        check("R1 count after reset", int'(brg_count), 0);
        for (int k = 0; k < 5; k++) tick_once(0);
        check("R1 ticks ignored scl", int'(scl_o), 1);
        check("R1 ticks ignored count", int'(brg_count), 0);

        // R5, R2, R6: walk the vector table.
        for (int v = 0; v < NVEC; v++) begin
            pulse_write(VEC_CFG[v]);
            check("R3 count loaded on write", int'(brg_count), VEC_HALF[v] - 1);
            measure_half(VEC_GAP[v], n);
            check("R5 first half period", n, VEC_HALF[v]);
            check("R6 reload after rollover", int'(brg_count), VEC_HALF[v] - 1);
            measure_half(VEC_GAP[v], n);
            check("R5 second half period", n, VEC_HALF[v]);
            @(negedge clk);
            check("R10 roll drops after one cycle", int'(roll_o), 0);
            pulse_done();
        end

        // R4: no decrement without a tick, then exactly one per tick.
        pulse_write(8'h10);
        repeat (10) @(negedge clk);
        check("R4 hold without tick", int'(brg_count), 16);
        tick_once(0);
        check("R4 one tick one step", int'(brg_count), 15);
        tick_once(3);
        check("R4 second phase step", int'(brg_count), 14);
        pulse_done();

        // R7: stretch of the high phase by a slave holding the line low.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        r = 2;
        pulse_write(8'(r));
        measure_half(0, n); // 1 -> 0
        measure_half(0, n); // 0 -> 1
        check("R7 released high", int'(scl_o), 1);
        hold_low = 1'b1;
        for (int k = 0; k < r + 1 + 4; k++) tick_once(0);
        check("R7 no toggle while stretched", int'(scl_o), 1);
        check("R7 parked at zero", int'(brg_count), 0);
        hold_low = 1'b0;
        tick_once(0);
        check("R7 toggle after release", int'(scl_o), 0);
        check("R7 reload after release", int'(brg_count), r);

        // R8: halt in the middle of a half period.
        tick_once(0);
        pulse_done();
        check("R8 count parked", int'(brg_count), 0);
        check("R8 scl held low", int'(scl_o), 0);
        for (int k = 0; k < 12; k++) tick_once(0);
        check("R8 scl still held", int'(scl_o), 0);
        check("R8 count still parked", int'(brg_count), 0);

        // R9: write and done in the same cycle.
        baud_cfg  = 8'h03;
        buf_wr    = 1'b1;
        xfer_done = 1'b1;
        @(negedge clk);
        buf_wr    = 1'b0;
        xfer_done = 1'b0;
        check("R9 write wins load", int'(brg_count), 3);
        measure_half(0, n);
        check("R9 still running", n, 4);

        // R1: reset in the middle of a run releases SCL high.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid-run reset scl", int'(scl_o), 1);
        check("R1 mid-run reset count", int'(brg_count), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule